// File: doc/BRIEF.md
# Flag-Producing 8-bit Arithmetic and Logic Unit

This block computes one arithmetic, logical or relational operation on two 8-bit operands. It returns an 8-bit result with four status flags: zero, negative, signed overflow and carry. The operations are add, subtract, multiply, unsigned divide, unsigned modulo, bitwise and, or and not, and six unsigned comparisons. Each comparison returns 1 when it holds and 0 when it does not. Division by zero gives a defined result and raises the overflow flag.

Requests arrive on a valid/ready stream carrying an opcode and two operands. The block computes the result combinationally and holds it in one output register, which it presents on a second valid/ready stream. A request is taken when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output and all flags stay frozen and no new request is accepted. This back-pressure reaches the producer in the same cycle, with no extra buffering.

Top module: `flag_alu`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. A request accepted at one clock edge appears on the outputs with `out_valid` high after that edge. `out_valid` drops after an edge where `out_ready` is high and `in_valid` is low.
- R2: While `out_valid` is high and `out_ready` is low, `out_result` and all four flags keep their values.
- R3: ADD (opcode 0) gives `(a+b) mod 256`. Carry is the carry out of bit 7. Overflow is set when both operands have the same bit 7 and the result's bit 7 differs from it.
- R4: SUB (opcode 1) gives `(a-b) mod 256`. Carry is set when a borrow occurs (`a < b` unsigned). Overflow is set when the operands differ in bit 7 and the result's bit 7 differs from that of `a`.
- R5: MUL (opcode 2) gives the low 8 bits of the 16-bit product. Carry and overflow are both set when the high 8 bits are nonzero.
- R6: DIV (opcode 3) and MOD (opcode 4) give the unsigned quotient and remainder. With a nonzero divisor, carry and overflow are clear.
- R7: With `b == 0`, DIV gives 0xFF and MOD gives `a`. Overflow is set and carry is clear.
- R8: AND (opcode 5), OR (opcode 6) and NOT (opcode 7, `~a`; `b` has no effect) are bitwise. Carry and overflow are clear.
- R9: EQ, NEQ, LT, LE, GT and GE (opcodes 8 to 13, in that order) compare unsigned and give 1 or 0. Carry and overflow are clear.
- R10: For every opcode, zero is set exactly when the 8-bit result is 0, and negative equals result bit 7.
- R11: Opcodes 14 and 15 are unused. They give result 0 with zero set and the other three flags clear.
- R12: While `rst_n` is low and after it is released, `out_valid` is low until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request this cycle |
| in_op | input | 4 | Operation code (see R3 to R11) |
| in_a | input | 8 | First operand |
| in_b | input | 8 | Second operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 8 | Operation result |
| out_zero | output | 1 | Result is zero |
| out_neg | output | 1 | Result bit 7 |
| out_ovf | output | 1 | Signed overflow, wide product, or division by zero |
| out_carry | output | 1 | Carry out, borrow, or wide product |

## Verification
Every opcode, including the two unused ones, is applied with all 256 values of `a`. The values of `b` are grouped into 0, small values, values around the sign boundary (125 to 131), values near 255, and a few alternating bit patterns. Values around the sign boundary tell signed overflow apart from unsigned carry or borrow, and they also tell unsigned comparisons apart from signed ones. A divisor of 0 isolates the division-by-zero rule from ordinary quotients. Values near 255 push multiplication into a nonzero high byte. A stall with `out_ready` held low, followed by release, shows that the result is frozen and that the refused request is taken later and is not lost.

// File: rtl/flag_alu_pkg.sv
`timescale 1ns/1ps
package flag_alu_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MUL  = 4'd2,
    OP_DIV  = 4'd3,
    OP_MOD  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_NOT  = 4'd7,
    OP_EQ   = 4'd8,
    OP_NEQ  = 4'd9,
    OP_LT   = 4'd10,
    OP_LE   = 4'd11,
    OP_GT   = 4'd12,
    OP_GE   = 4'd13,
    OP_RSVA = 4'd14,
    OP_RSVB = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic zero;
    logic neg;
    logic ovf;
    logic carry;
  } alu_flags_t;

endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);
  localparam int unsigned MSB = W - 1;

  logic [W:0] ext;

  always_comb begin
    if (sub) ext = {1'b0, a} - {1'b0, b};
    else     ext = {1'b0, a} + {1'b0, b};
    sum   = ext[W-1:0];
    // For subtraction the wrapped top bit is the borrow.
    carry = ext[W];
    if (sub) ovf = (a[MSB] != b[MSB]) && (ext[MSB] != a[MSB]);
    else     ovf = (a[MSB] == b[MSB]) && (ext[MSB] != a[MSB]);
  end
endmodule

// File: rtl/alu_mul.sv
`timescale 1ns/1ps
module alu_mul #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] low,
  output logic         wide
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] prod;

  always_comb begin
    prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    low  = prod[W-1:0];
    wide = |prod[PW-1:W];
  end
endmodule

// File: rtl/alu_divmod.sv
`timescale 1ns/1ps
module alu_divmod #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         by_zero
);
  logic [W-1:0] part;
  logic [W-1:0] q;
  logic [W:0]   shifted;
  logic [W:0]   trial;

  // Restoring division, one quotient bit per step, most significant first.
  always_comb begin
    part    = '0;
    q       = '0;
    shifted = '0;
    trial   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      shifted = {part, a[i]};
      trial   = shifted - {1'b0, b};
      if (!trial[W]) begin
        q[i] = 1'b1;
        part = trial[W-1:0];
      end else begin
        part = shifted[W-1:0];
      end
    end
  end

  always_comb begin
    by_zero = (b == '0);
    quot    = by_zero ? {W{1'b1}} : q;
    rem     = by_zero ? a : part;
  end
endmodule

// File: rtl/alu_logic_cmp.sv
`timescale 1ns/1ps
module alu_logic_cmp
  import flag_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result
);
  logic truth;

  always_comb begin
    truth = 1'b0;
    unique case (op)
      OP_EQ:   truth = (a == b);
      OP_NEQ:  truth = (a != b);
      OP_LT:   truth = (a <  b);
      OP_LE:   truth = (a <= b);
      OP_GT:   truth = (a >  b);
      OP_GE:   truth = (a >= b);
      default: truth = 1'b0;
    endcase
  end

  always_comb begin
    case (op)
      OP_AND:  result = a & b;
      OP_OR:   result = a | b;
      OP_NOT:  result = ~a;
      OP_EQ, OP_NEQ, OP_LT, OP_LE, OP_GT, OP_GE:
               result = {{(W-1){1'b0}}, truth};
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/flag_alu.sv
`timescale 1ns/1ps
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [3:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_zero,
  output logic         out_neg,
  output logic         out_ovf,
  output logic         out_carry
);
  localparam int unsigned MSB = W - 1;

  alu_op_e      op;
  logic [W-1:0] as_sum, mul_lo, dv_q, dv_r, lc_res;
  logic         as_c, as_o, mul_wide, dv_z;
  logic [W-1:0] nxt_res;
  alu_flags_t   nxt_flg;
  alu_flags_t   flg_q;
  logic         take;

  assign op = alu_op_e'(in_op);

  alu_addsub #(.W(W)) u_addsub (
    .a(in_a), .b(in_b), .sub(op == OP_SUB),
    .sum(as_sum), .carry(as_c), .ovf(as_o)
  );

  alu_mul #(.W(W)) u_mul (
    .a(in_a), .b(in_b), .low(mul_lo), .wide(mul_wide)
  );

  alu_divmod #(.W(W)) u_divmod (
    .a(in_a), .b(in_b), .quot(dv_q), .rem(dv_r), .by_zero(dv_z)
  );

  alu_logic_cmp #(.W(W)) u_logic (
    .op(op), .a(in_a), .b(in_b), .result(lc_res)
  );

  always_comb begin
    nxt_res       = lc_res;
    nxt_flg.carry = 1'b0;
    nxt_flg.ovf   = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin
        nxt_res       = as_sum;
        nxt_flg.carry = as_c;
        nxt_flg.ovf   = as_o;
      end
      OP_MUL: begin
        nxt_res       = mul_lo;
        nxt_flg.carry = mul_wide;
        nxt_flg.ovf   = mul_wide;
      end
      OP_DIV: begin
        nxt_res     = dv_q;
        nxt_flg.ovf = dv_z;
      end
      OP_MOD: begin
        nxt_res     = dv_r;
        nxt_flg.ovf = dv_z;
      end
      default: nxt_res = lc_res;
    endcase
    nxt_flg.zero = (nxt_res == '0);
    nxt_flg.neg  = nxt_res[MSB];
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      flg_q      <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_result <= nxt_res;
        flg_q      <= nxt_flg;
      end
    end
  end

  assign out_zero  = flg_q.zero;
  assign out_neg   = flg_q.neg;
  assign out_ovf   = flg_q.ovf;
  assign out_carry = flg_q.carry;
endmodule

// File: rtl/flag_alu_chk.sv
`timescale 1ns/1ps
module flag_alu_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [3:0]   in_op,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result,
  input logic         out_zero,
  input logic         out_neg,
  input logic         out_ovf,
  input logic         out_carry
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R1
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R1
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
      && $stable(out_zero) && $stable(out_neg)
      && $stable(out_ovf) && $stable(out_carry)));

  // R7
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 4'd3 && in_b == '0) |=> (out_result == {W{1'b1}} && out_ovf && !out_carry));

  // R8
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op >= 4'd5 && in_op <= 4'd7) |=> (!out_ovf && !out_carry));

  // R9
  cmp_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op >= 4'd8 && in_op <= 4'd13) |=> (out_result <= 1 && !out_ovf && !out_carry));

  // R10
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_zero == (out_result == '0)));

  // R10
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_neg == out_result[W-1]));

  // R11
  unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op >= 4'd14) |=> (out_result == '0 && out_zero && !out_ovf && !out_carry));

  // R12
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (.*);

// File: tb/tb_flag_alu.sv
`timescale 1ns/1ps
module tb_flag_alu;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [3:0]   in_op = '0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_result;
  logic         out_zero, out_neg, out_ovf, out_carry;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  flag_alu #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_zero(out_zero), .out_neg(out_neg),
    .out_ovf(out_ovf), .out_carry(out_carry)
  );

  function automatic int sgn(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  // Expected outputs worked out arithmetically from R3..R11.
  function automatic void model(input int op, input int a, input int b,
                                output int r, output bit z, output bit n,
                                output bit o, output bit c);
    int s;
    r = 0; o = 1'b0; c = 1'b0;
    case (op)
      0: begin s = a + b; r = s % 256; c = (s > 255);
               s = sgn(a) + sgn(b); o = (s > 127) || (s < -128); end
      1: begin r = (a - b + 256) % 256; c = (a < b);
               s = sgn(a) - sgn(b); o = (s > 127) || (s < -128); end
      2: begin s = a * b; r = s % 256; c = (s > 255); o = c; end
      3: begin if (b == 0) begin r = 255; o = 1'b1; end else r = a / b; end
      4: begin if (b == 0) begin r = a; o = 1'b1; end else r = a % b; end
      5: r = a & b;
      6: r = a | b;
      7: r = 255 - a;
      8: r = (a == b) ? 1 : 0;
      9: r = (a != b) ? 1 : 0;
      10: r = (a < b) ? 1 : 0;
      11: r = (a <= b) ? 1 : 0;
      12: r = (a > b) ? 1 : 0;
      13: r = (a >= b) ? 1 : 0;
      default: r = 0;
    endcase
    z = (r == 0);
    n = (r >= 128);
  endfunction

  function automatic string req_of(input int op, input int b);
    case (op)
      0: return "R3/R10";
      1: return "R4/R10";
      2: return "R5/R10";
      3, 4: return (b == 0) ? "R7/R10" : "R6/R10";
      5, 6, 7: return "R8/R10";
      14, 15: return "R11";
      default: return "R9/R10";
    endcase
  endfunction

  task automatic check_result(input int op, input int a, input int b);
    int er; bit ez, en, eo, ec;
    model(op, a, b, er, ez, en, eo, ec);
    checks++;
    if (!out_valid || out_result != er[W-1:0] || out_zero != ez ||
        out_neg != en || out_ovf != eo || out_carry != ec) begin
      fails++;
      $display("FAIL %s op=%0d a=%0d b=%0d got v=%0b r=%0d z%0b n%0b o%0b c%0b exp v=1 r=%0d z%0b n%0b o%0b c%0b",
               req_of(op, b), op, a, b, out_valid, out_result, out_zero, out_neg,
               out_ovf, out_carry, er, ez, en, eo, ec);
    end
  endtask

  task automatic check_bit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int blist [26] = '{0, 1, 2, 3, 4, 5, 6, 7, 125, 126, 127, 128, 129, 130, 131,
                       248, 249, 250, 251, 252, 253, 254, 255, 64, 85, 170};
    int pop, pa, pb;
    bit have;
    have = 1'b0; pop = 0; pa = 0; pb = 0;

    repeat (3) @(negedge clk);
    // R12: idle during reset
    check_bit("R12 out_valid in reset", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R12 out_valid after reset", out_valid, 1'b0);
    check_bit("R1 in_ready when empty", in_ready, 1'b1);

    // Sweep: every opcode, all a, grouped b; one request per cycle.
    out_ready = 1'b1;
    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int bi = 0; bi < 26; bi++) begin
          if (have) check_result(pop, pa, pb);
          in_valid = 1'b1;
          in_op = op[3:0];
          in_a = a[W-1:0];
          in_b = blist[bi][W-1:0];
          pop = op; pa = a; pb = blist[bi];
          have = 1'b1;
          @(negedge clk);
        end
      end
    end
    check_result(pop, pa, pb);
    in_valid = 1'b0;
    @(negedge clk);
    // R1: drains when consumer ready and no request
    check_bit("R1 out_valid drains", out_valid, 1'b0);

    // Back-pressure: R1 and R2
    in_valid = 1'b1; in_op = 4'd0; in_a = 8'd1; in_b = 8'd2;
    @(negedge clk);
    check_result(0, 1, 2);
    out_ready = 1'b0;
    in_op = 4'd1; in_a = 8'd9; in_b = 8'd4;
    repeat (2) begin
      @(negedge clk);
      check_bit("R1 in_ready low while stalled", in_ready, 1'b0);
      // R2: held result of ADD 1+2
      check_result(0, 1, 2);
    end
    out_ready = 1'b1;
    @(negedge clk);
    // R1: stalled request accepted after release
    check_result(1, 9, 4);
    in_valid = 1'b0;
    @(negedge clk);
    check_bit("R1 out_valid drains after stall", out_valid, 1'b0);

    // R8: NOT ignores b, seen on the result for two different b values
    in_valid = 1'b1; in_op = 4'd7; in_a = 8'h5A; in_b = 8'h00;
    @(negedge clk);
    check_result(7, 8'h5A, 0);
    in_b = 8'hFF;
    @(negedge clk);
    check_result(7, 8'h5A, 255);
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule